// File: doc/BRIEF.md
# Exception Priority Masking Arbiter

This block decides which pending exception, if any, the core should take next. It looks at a vector of external interrupt requests, each with its own configurable priority, plus two system exceptions with fixed priorities: a non-maskable interrupt and a hard fault. It also looks at the current execution priority and at three masking controls. Requests that the masks forbid are removed first. The most urgent survivor is then picked. A take request is raised only if the survivor outranks whatever is running now.

Priorities follow the convention that a smaller number is more urgent. Configurable priorities are unsigned `PRIO_W`-bit values. The arbiter works internally on a signed value two bits wider, so that the fixed levels of the non-maskable interrupt (-2) and the hard fault (-1) sit above every configurable level. The current execution priority uses the same signed encoding, so a value of 2^PRIO_W or above means that no exception is active. The result is registered, and it appears one clock after the inputs that produced it. Fetching the vector, stacking registers and chaining handlers belong to the surrounding logic.

Top module: `exc_mask_arb`

## Requirements
- R1: Exception numbers are encoded as follows: non-maskable interrupt = 2, hard fault = 3, external interrupt i = 16 + i. The outputs `take_req`, `take_num` and `take_prio` reflect the inputs sampled at the previous rising clock edge.
- R2: The non-maskable interrupt has effective priority -2 and the hard fault has -1. Both win over any pending external interrupt, and the non-maskable interrupt wins over the hard fault.
- R3: Among eligible external interrupts, the smallest priority value wins. On equal priority, the lower exception number wins.
- R4: While `global_mask` is 1, no external interrupt is eligible. The non-maskable interrupt and the hard fault stay eligible.
- R5: While `fault_mask` is 1, only the non-maskable interrupt is eligible, whatever the value of `global_mask`.
- R6: While `base_thresh` is nonzero, an external interrupt whose priority value is greater than or equal to `base_thresh` is not eligible. The threshold never blocks the non-maskable interrupt or the hard fault.
- R7: A `base_thresh` of zero blocks nothing.
- R8: `take_req` is 1 only when the winner's effective priority is strictly less than the signed `exec_prio`. In that case `take_num` carries the winner's number and `take_prio` carries its effective priority, as a signed value.
- R9: While `rst_n` is low, `take_req`, `take_num` and `take_prio` are 0.
- R10: When `take_req` is 0, `take_num` and `take_prio` are 0. With nothing eligible, `take_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pend | input | NUM_IRQ | Pending flag per external interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority of interrupt i in bits [i*PRIO_W +: PRIO_W] |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| hardfault_pend | input | 1 | Hard fault pending |
| exec_prio | input | PRIO_W+2 | Signed current execution priority |
| global_mask | input | 1 | Blocks all external interrupts |
| fault_mask | input | 1 | Blocks everything except the non-maskable interrupt |
| base_thresh | input | PRIO_W | Priority threshold for external interrupts, 0 = off |
| take_req | output | 1 | Take the exception named by take_num |
| take_num | output | $clog2(16+NUM_IRQ) | Winning exception number |
| take_prio | output | PRIO_W+2 | Signed effective priority of the winner |

## Verification
Every result of this block is due exactly one rising edge after the inputs that decide it. The block has no further state, so all three outputs settle together and no later edge changes them. The bench changes the inputs on the falling edge. It waits for the next rising edge and samples a couple of nanoseconds after it, then compares the outputs against a model that scans the same inputs linearly. The inputs are held until the next falling edge, so each sample reflects exactly the inputs of one stimulus. For the reset checks, the outputs are sampled while `rst_n` is still low.

// File: rtl/exc_arb_pkg.sv
package exc_arb_pkg;
  localparam int NMI_NUM  = 2;
  localparam int HF_NUM   = 3;
  localparam int IRQ_BASE = 16;
  localparam int NMI_PRIO = -2;
  localparam int HF_PRIO  = -1;

  // width of an exception number for a given count of external sources
  function automatic int exc_num_width(input int n_irq);
    return $clog2(IRQ_BASE + n_irq);
  endfunction
endpackage

// File: rtl/exc_mask_filter.sv
module exc_mask_filter
  import exc_arb_pkg::*;
#(
  parameter int NUM_IRQ = 240,
  parameter int PRIO_W  = 8
) (
  input  logic [NUM_IRQ-1:0]          irq_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
  input  logic                        nmi_pend,
  input  logic                        hardfault_pend,
  input  logic                        global_mask,
  input  logic                        fault_mask,
  input  logic [PRIO_W-1:0]           base_thresh,
  output logic [NUM_IRQ+1:0]          leaf_valid,
  output logic [NUM_IRQ+1:0][PRIO_W+1:0] leaf_prio
);
  localparam int PX = PRIO_W + 2;

  // threshold blocks a configurable priority at or below its level
  function automatic logic thresh_blocks(input logic [PRIO_W-1:0] p,
                                         input logic [PRIO_W-1:0] t);
    return (t != '0) && (p >= t);
  endfunction

  assign leaf_valid[0] = nmi_pend;
  assign leaf_prio[0]  = PX'(NMI_PRIO);
  assign leaf_valid[1] = hardfault_pend && !fault_mask;
  assign leaf_prio[1]  = PX'(HF_PRIO);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    logic [PRIO_W-1:0] p;
    assign p                 = irq_prio[i*PRIO_W +: PRIO_W];
    assign leaf_valid[i+2]   = irq_pend[i] && !global_mask && !fault_mask &&
                               !thresh_blocks(p, base_thresh);
    assign leaf_prio[i+2]    = {2'b00, p};
  end
endmodule

// File: rtl/exc_prio_tree.sv
module exc_prio_tree #(
  parameter int LEAF_N = 242,
  parameter int PX     = 10,
  parameter int IDX_W  = 8
) (
  input  logic [LEAF_N-1:0]         leaf_valid,
  input  logic [LEAF_N-1:0][PX-1:0] leaf_prio,
  output logic                      win_valid,
  output logic [PX-1:0]             win_prio,
  output logic [IDX_W-1:0]          win_idx
);
  localparam int NL    = 1 << IDX_W;
  localparam int NODES = 2 * NL - 1;

  // left child (lower leaf index) keeps ties
  function automatic logic keep_left(input logic va, input logic [PX-1:0] pa,
                                     input logic vb, input logic [PX-1:0] pb);
    return va && (!vb || ($signed(pa) <= $signed(pb)));
  endfunction

  logic             nv [NODES];
  logic [PX-1:0]    np [NODES];
  logic [IDX_W-1:0] ni [NODES];

  for (genvar l = 0; l < NL; l++) begin : g_leaf
    if (l < LEAF_N) begin : g_real
      assign nv[NL-1+l] = leaf_valid[l];
      assign np[NL-1+l] = leaf_prio[l];
    end else begin : g_pad
      assign nv[NL-1+l] = 1'b0;
      assign np[NL-1+l] = '0;
    end
    assign ni[NL-1+l] = IDX_W'(l);
  end

  for (genvar k = 0; k < NL - 1; k++) begin : g_node
    logic left;
    assign left  = keep_left(nv[2*k+1], np[2*k+1], nv[2*k+2], np[2*k+2]);
    assign nv[k] = nv[2*k+1] || nv[2*k+2];
    assign np[k] = left ? np[2*k+1] : np[2*k+2];
    assign ni[k] = left ? ni[2*k+1] : ni[2*k+2];
  end

  assign win_valid = nv[0];
  assign win_prio  = np[0];
  assign win_idx   = ni[0];
endmodule

// File: rtl/exc_mask_arb.sv
module exc_mask_arb
  import exc_arb_pkg::*;
#(
  parameter int NUM_IRQ = 240,
  parameter int PRIO_W  = 8,
  localparam int EXC_W  = exc_num_width(NUM_IRQ)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_pend,
  input  logic [NUM_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic                       nmi_pend,
  input  logic                       hardfault_pend,
  input  logic signed [PRIO_W+1:0]   exec_prio,
  input  logic                       global_mask,
  input  logic                       fault_mask,
  input  logic [PRIO_W-1:0]          base_thresh,
  output logic                       take_req,
  output logic [EXC_W-1:0]           take_num,
  output logic [PRIO_W+1:0]          take_prio
);
  localparam int PX     = PRIO_W + 2;
  localparam int LEAF_N = NUM_IRQ + 2;
  localparam int IDX_W  = $clog2(LEAF_N);

  // leaf 0 = NMI, leaf 1 = hard fault, leaf k>=2 = IRQ k-2
  function automatic logic [EXC_W-1:0] leaf_to_exc(input logic [IDX_W-1:0] k);
    if (k == IDX_W'(0)) return EXC_W'(NMI_NUM);
    if (k == IDX_W'(1)) return EXC_W'(HF_NUM);
    return EXC_W'(k) + EXC_W'(IRQ_BASE - 2);
  endfunction

  logic [LEAF_N-1:0]         leaf_valid;
  logic [LEAF_N-1:0][PX-1:0] leaf_prio;
  logic                      win_valid;
  logic [PX-1:0]             win_prio;
  logic [IDX_W-1:0]          win_idx;
  logic                      take_now;
  logic [EXC_W-1:0]          win_num;

  exc_mask_filter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_filter (
    .irq_pend       (irq_pend),
    .irq_prio       (irq_prio),
    .nmi_pend       (nmi_pend),
    .hardfault_pend (hardfault_pend),
    .global_mask    (global_mask),
    .fault_mask     (fault_mask),
    .base_thresh    (base_thresh),
    .leaf_valid     (leaf_valid),
    .leaf_prio      (leaf_prio)
  );

  exc_prio_tree #(.LEAF_N(LEAF_N), .PX(PX), .IDX_W(IDX_W)) u_tree (
    .leaf_valid (leaf_valid),
    .leaf_prio  (leaf_prio),
    .win_valid  (win_valid),
    .win_prio   (win_prio),
    .win_idx    (win_idx)
  );

  assign win_num  = leaf_to_exc(win_idx);
  assign take_now = win_valid && ($signed(win_prio) < exec_prio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_req  <= 1'b0;
      take_num  <= '0;
      take_prio <= '0;
    end else begin
      take_req  <= take_now;
      take_num  <= take_now ? win_num  : '0;
      take_prio <= take_now ? win_prio : '0;
    end
  end
endmodule

// File: rtl/exc_mask_arb_chk.sv
module exc_mask_arb_chk #(
  parameter int NUM_IRQ = 240,
  parameter int PRIO_W  = 8,
  parameter int EXC_W   = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_IRQ-1:0]       irq_pend,
  input logic                     nmi_pend,
  input logic                     hardfault_pend,
  input logic signed [PRIO_W+1:0] exec_prio,
  input logic                     global_mask,
  input logic                     fault_mask,
  input logic [PRIO_W-1:0]        base_thresh,
  input logic                     take_now,
  input logic                     take_req,
  input logic [EXC_W-1:0]         take_num,
  input logic [PRIO_W+1:0]        take_prio
);
  logic [NUM_IRQ-1:0] pend_prev;
  logic [NUM_IRQ-1:0] pend_shift;
  always_ff @(posedge clk) pend_prev <= irq_pend;
  assign pend_shift = pend_prev >> (take_num - EXC_W'(16));

  // R8
  gate_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && $past(rst_n) |-> $signed(take_prio) < $past(exec_prio));
  // R8
  issue_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |=> take_req);
  // R5
  fault_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && $past(rst_n) && $past(fault_mask) |-> take_num == EXC_W'(2));
  // R4
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && $past(rst_n) && $past(global_mask) |->
      (take_num == EXC_W'(2) || take_num == EXC_W'(3)));
  // R6
  thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && $past(rst_n) && $past(base_thresh) != '0 && take_num >= EXC_W'(16) |->
      take_prio < {2'b00, $past(base_thresh)});
  // R2
  nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(nmi_pend) && ($past(exec_prio) > -2) |->
      take_req && take_num == EXC_W'(2));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(nmi_pend) && !$past(hardfault_pend) &&
      $past(irq_pend) == '0 |-> !take_req);
  // R1
  src_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && $past(rst_n) && take_num >= EXC_W'(16) |-> pend_shift[0]);
endmodule

bind exc_mask_arb exc_mask_arb_chk #(
  .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .EXC_W(EXC_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .irq_pend       (irq_pend),
  .nmi_pend       (nmi_pend),
  .hardfault_pend (hardfault_pend),
  .exec_prio      (exec_prio),
  .global_mask    (global_mask),
  .fault_mask     (fault_mask),
  .base_thresh    (base_thresh),
  .take_now       (take_now),
  .take_req       (take_req),
  .take_num       (take_num),
  .take_prio      (take_prio)
);

// File: tb/tb_exc_mask_arb.sv
`timescale 1ns/1ps
module tb_exc_mask_arb;
  localparam int N   = 6;
  localparam int PW  = 3;
  localparam int EXW = PW + 2;
  localparam int NW  = $clog2(16 + N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    irq_pend = '0;
  logic [N*PW-1:0] irq_prio = '0;
  logic nmi_pend = 1'b0, hardfault_pend = 1'b0;
  logic signed [EXW-1:0] exec_prio = EXW'(8);
  logic global_mask = 1'b0, fault_mask = 1'b0;
  logic [PW-1:0] base_thresh = '0;
  logic take_req;
  logic [NW-1:0]  take_num;
  logic [EXW-1:0] take_prio;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_mask_arb #(.NUM_IRQ(N), .PRIO_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_prio(irq_prio),
    .nmi_pend(nmi_pend), .hardfault_pend(hardfault_pend), .exec_prio(exec_prio),
    .global_mask(global_mask), .fault_mask(fault_mask), .base_thresh(base_thresh),
    .take_req(take_req), .take_num(take_num), .take_prio(take_prio)
  );

  // linear scan over candidates in ascending exception number
  function automatic void model(output bit t, output int num, output int pr);
    int bn = -1;
    int bp = 1 << 20;
    if (nmi_pend) begin bn = 2; bp = -2; end
    if (hardfault_pend && !fault_mask && -1 < bp) begin bn = 3; bp = -1; end
    for (int i = 0; i < N; i++) begin
      int p = int'(irq_prio[i*PW +: PW]);
      bit ok = irq_pend[i] && !global_mask && !fault_mask &&
               (base_thresh == 0 || p < int'(base_thresh));
      if (ok && p < bp) begin bn = 16 + i; bp = p; end
    end
    t   = (bn >= 0) && (bp < int'(exec_prio));
    num = t ? bn : 0;
    pr  = t ? bp : 0;
  endfunction

  task automatic compare(input string tag, input bit et, input int en, input int ep);
    int an = int'(take_num);
    int ap = int'($signed(take_prio));
    n_run++;
    if (take_req !== et || an != en || ap != ep) begin
      n_fail++;
      $display("FAIL %s: got req=%0d num=%0d prio=%0d, expected req=%0d num=%0d prio=%0d",
               tag, take_req, an, ap, et, en, ep);
    end
  endtask

  // inputs were set after a falling edge; result is due at the next rising edge
  task automatic step_check(input string tag);
    bit t; int n; int p;
    @(posedge clk); #2;
    model(t, n, p);
    compare(tag, t, n, p);
    @(negedge clk);
  endtask

  task automatic clear_in();
    irq_pend = '0; irq_prio = '0; nmi_pend = 0; hardfault_pend = 0;
    exec_prio = EXW'(8); global_mask = 0; fault_mask = 0; base_thresh = '0;
  endtask

  task automatic set_prio(input int i, input int p);
    irq_prio[i*PW +: PW] = PW'(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int ev[6] = '{-2, -1, 0, 3, 7, 8};
    // R9: outputs idle in reset even with a request present
    nmi_pend = 1;
    repeat (2) @(posedge clk);
    #2 compare("R9 reset", 0, 0, 0);
    @(negedge clk); rst_n = 1; clear_in();
    @(negedge clk);

    // R10: nothing pending
    step_check("R10 none pending");
    // R1: single IRQ 3 -> number 19
    irq_pend[3] = 1; set_prio(3, 5);
    step_check("R1 irq3");
    compare("R1 irq3 encoding", 1, 19, 5);
    // R2: NMI beats hard fault and priority-0 IRQ
    clear_in(); nmi_pend = 1; hardfault_pend = 1; irq_pend[0] = 1;
    step_check("R2 nmi wins");
    compare("R2 nmi number", 1, 2, -2);
    nmi_pend = 0;
    step_check("R2 hardfault wins");
    compare("R2 hardfault number", 1, 3, -1);
    // R3: tie between IRQ1 and IRQ4 -> 17; lower value wins over index
    clear_in(); irq_pend[1] = 1; irq_pend[4] = 1; set_prio(1, 2); set_prio(4, 2);
    step_check("R3 tie");
    compare("R3 tie number", 1, 17, 2);
    set_prio(4, 1);
    step_check("R3 lower value");
    compare("R3 lower value number", 1, 20, 1);
    // R4: global mask keeps hard fault only
    clear_in(); global_mask = 1; hardfault_pend = 1; irq_pend[2] = 1;
    step_check("R4 global keeps hf");
    compare("R4 global hf number", 1, 3, -1);
    hardfault_pend = 0;
    step_check("R4 global blocks irq");
    compare("R4 blocked", 0, 0, 0);
    // R5: fault mask, also over global mask
    clear_in(); fault_mask = 1; global_mask = 1; hardfault_pend = 1;
    step_check("R5 hf blocked");
    compare("R5 hf blocked ports", 0, 0, 0);
    nmi_pend = 1;
    step_check("R5 nmi passes");
    compare("R5 nmi ports", 1, 2, -2);
    // R6: threshold 4 blocks prio 4, passes prio 3, never hard fault
    clear_in(); base_thresh = 3'd4; irq_pend[0] = 1; set_prio(0, 4);
    step_check("R6 equal blocked");
    compare("R6 equal blocked ports", 0, 0, 0);
    irq_pend[5] = 1; set_prio(5, 3);
    step_check("R6 below passes");
    compare("R6 below ports", 1, 21, 3);
    base_thresh = 3'd1; hardfault_pend = 1;
    step_check("R6 hf unaffected");
    compare("R6 hf ports", 1, 3, -1);
    // R7: zero threshold blocks nothing
    clear_in(); irq_pend[2] = 1; set_prio(2, 7);
    step_check("R7 zero thresh");
    compare("R7 zero thresh ports", 1, 18, 7);
    // R8: strict comparison with execution priority
    clear_in(); irq_pend[1] = 1; set_prio(1, 3); exec_prio = EXW'(3);
    step_check("R8 equal not taken");
    compare("R8 equal ports", 0, 0, 0);
    set_prio(1, 2);
    step_check("R8 higher taken");
    clear_in(); exec_prio = -5'sd1; hardfault_pend = 1;
    step_check("R8 hf vs -1");
    compare("R8 hf vs -1 ports", 0, 0, 0);
    nmi_pend = 1;
    step_check("R8 nmi vs -1");

    // sweep: every mask combination, threshold and execution level
    for (int pat = 0; pat < 6; pat++) begin
      logic [N-1:0]    pp = N'($urandom);
      logic [N*PW-1:0] pr = (N*PW)'($urandom);
      bit nm = ($urandom % 5) == 0;
      bit hf = ($urandom % 3) == 0;
      for (int g = 0; g < 2; g++)
        for (int f = 0; f < 2; f++)
          for (int b = 0; b < 8; b++)
            for (int e = 0; e < 6; e++) begin
              irq_pend = pp; irq_prio = pr; nmi_pend = nm; hardfault_pend = hf;
              global_mask = g[0]; fault_mask = f[0]; base_thresh = PW'(b);
              exec_prio = EXW'(ev[e]);
              if (f != 0)      step_check("R5 sweep");
              else if (g != 0) step_check("R4 sweep");
              else if (b != 0) step_check("R6 sweep");
              else             step_check("R8 sweep");
            end
    end

    // R9: reset mid-run clears a pending result
    clear_in(); nmi_pend = 1;
    step_check("R9 before reset");
    rst_n = 0; #2;
    compare("R9 async clear", 0, 0, 0);
    @(negedge clk); rst_n = 1; clear_in();
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule